// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between one processor core and a single memory port and gives the core total-store-order behaviour. A store is written into an in-order queue and the core moves on at once. The queue drains to memory one entry at a time, oldest first. A later load whose address is held by no queued store may reach memory before those older stores. A load whose address is held by a queued store is answered from the queue and never goes to memory.

Three fence commands let software put order back where it needs it. A load fence waits for the outstanding load. A store fence waits until every queued and in-flight store has been acknowledged. A full fence waits for both. A fence is held on the request port with ready low until its condition holds, so nothing behind it can be accepted. The memory side uses a valid/ready request channel. Responses come back in request order, one for every request, stores included.

Request op encoding on `cpu_req_op`: 0 load, 1 store, 2 load fence, 3 store fence, 4 full fence. Codes 5 to 7 act as a full fence.

Top module: `store_buffer_tso`

## Requirements
- R1: A store is accepted (`cpu_req_ready` high for op 1) whenever the queue holds fewer than DEPTH entries, whatever the state of the memory port.
- R2: A load whose address matches no queued store is presented on the memory port (`mem_req_write` low, its address) in the cycle after acceptance, even with older stores still queued.
- R3: A load whose address matches one or more queued stores is not sent to memory; `cpu_rsp_valid` rises in the cycle after acceptance with the data of the youngest matching store.
- R4: Stores reach the memory port in acceptance order, each exactly once, with their own address and data.
- R5: Stores are accepted while earlier stores are still pending and while a load is outstanding.
- R6: A store fence (op 3) is accepted only once the queue is empty and every issued store has been acknowledged by a memory response.
- R7: A load fence (op 2) is accepted only when no load is outstanding; queued stores do not hold it back.
- R8: A full fence (op 4, and ops 5 to 7) is accepted only when both the R6 and the R7 conditions hold.
- R9: Every load returns, in order, the value of the most recent earlier store to its address in program order, or the memory contents if there is none; a memory-served load answers on `cpu_rsp_valid` one cycle after its memory response.
- R10: With DEPTH stores queued, `cpu_req_ready` is low for a store.
- R11: When a load and a store both wait for the memory port, the load is issued first; at most one request is issued per cycle.
- R12: After reset the queue is empty, `mem_req_valid` and `cpu_rsp_valid` are low, and `cpu_req_ready` is high for a load.
- R13: A new load is held (`cpu_req_ready` low for op 0) while an earlier load is still waiting for memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Core request valid |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid is also high |
| cpu_req_op | input | 3 | Operation code (see encoding above) |
| cpu_req_addr | input | AW | Load or store address |
| cpu_req_wdata | input | DW | Store data |
| cpu_rsp_valid | output | 1 | Load data valid, one cycle |
| cpu_rsp_rdata | output | DW | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for store, 0 for load |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory store data |
| mem_rsp_valid | input | 1 | In-order response, one per request |
| mem_rsp_rdata | input | DW | Load data on a response |

## Verification
The bench builds the block with a queue depth of 4, 4-bit addresses, 16-bit data and two outstanding memory requests. The small depth lets the full-queue stall and the fence stalls be reached after a handful of stores. The narrow address space makes random loads hit queued stores often, so forwarding from the youngest of several matching entries occurs many times. The two-slot outstanding limit, together with random memory readiness and latency, exercises the case where a fence must wait for acknowledgements of stores that have already left the queue.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_STORE     = 3'd1,
    OP_FENCE_LD  = 3'd2,
    OP_FENCE_ST  = 3'd3,
    OP_FENCE_ALL = 3'd4
  } sb_op_e;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_ISSUE = 2'd1,
    LD_DATA  = 2'd2
  } ld_state_e;

endpackage

// File: rtl/sb_store_queue.sv
// In-order store queue with a youngest-match lookup port.
// DEPTH must be a power of two, at least 2.
module sb_store_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_en,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop_en,
  input  logic [AW-1:0]                look_addr,
  output logic                         head_valid,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         hit,
  output logic [DW-1:0]                hit_data
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, head_d;
  logic [PW-1:0] tail_q, tail_d;
  logic [CW-1:0] count_q, count_d;

  logic [DEPTH-1:0] slot_match;
  logic [PW-1:0]    slot_age [DEPTH];

  // next-state for pointers and occupancy
  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (pop_en) begin
      head_d = head_q + PW'(1);
    end
    if (push_en) begin
      tail_d = tail_q + PW'(1);
    end
    case ({push_en, pop_en})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  // entry storage, written at the tail when enabled
  always_ff @(posedge clk) begin
    if (push_en) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  // per-slot age and live match
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_age[g]   = PW'(g) - head_q;
    assign slot_match[g] = (CW'(slot_age[g]) < count_q) && (addr_q[g] == look_addr);
  end

  // pick the matching slot with the greatest age (youngest store)
  always_comb begin
    logic [PW-1:0] best_age;
    hit      = 1'b0;
    hit_data = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_match[i] && (!hit || slot_age[i] > best_age)) begin
        hit      = 1'b1;
        best_age = slot_age[i];
        hit_data = data_q[i];
      end
    end
  end

  assign head_valid = (count_q != '0);
  assign head_addr  = addr_q[head_q];
  assign head_data  = data_q[head_q];
  assign full       = (count_q == CW'(DEPTH));
  assign count      = count_q;

endmodule

// File: rtl/sb_tag_fifo.sv
// Records the kind (load or store) of each request in flight at memory,
// so that in-order responses can be routed. DEPTH power of two, at least 2.
module sb_tag_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_en,
  input  logic push_is_load,
  input  logic pop_en,
  output logic front_is_load,
  output logic full
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] kind_q;
  logic [PW-1:0]    rd_q, rd_d;
  logic [PW-1:0]    wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             pop_ok;

  assign pop_ok = pop_en && (cnt_q != '0);

  always_comb begin
    rd_d  = pop_ok  ? rd_q + PW'(1) : rd_q;
    wr_d  = push_en ? wr_q + PW'(1) : wr_q;
    cnt_d = cnt_q;
    case ({push_en, pop_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) begin
      kind_q[wr_q] <= push_is_load;
    end
  end

  assign front_is_load = (cnt_q != '0) && kind_q[rd_q];
  assign full          = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/sb_mem_arb.sv
// Single memory request channel: a waiting load wins over the queue head.
module sb_mem_arb #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic          st_req,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          room,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ld_grant,
  output logic          st_grant
);

  assign mem_valid = room && (ld_req || st_req);
  assign mem_write = !ld_req;
  assign mem_addr  = ld_req ? ld_addr : st_addr;
  assign mem_wdata = st_data;
  assign ld_grant  = mem_valid && mem_ready && ld_req;
  assign st_grant  = mem_valid && mem_ready && !ld_req;

endmodule

// File: rtl/store_buffer_tso.sv
module store_buffer_tso
  import sb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic [2:0]    cpu_req_op,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(MAX_OUT + 1);

  sb_op_e      op;
  ld_state_e   ld_state_q, ld_state_d;
  logic [AW-1:0] ld_addr_q;
  logic          ld_addr_en;
  logic [IW-1:0] st_inflight_q, st_inflight_d;
  logic          rsp_valid_q, rsp_valid_d;
  logic [DW-1:0] rsp_data_q, rsp_data_d;
  logic          rsp_data_en;

  logic          accept, ld_accept, st_accept, fwd_hit;
  logic          ld_idle, ld_waiting, st_quiet;

  logic          sq_head_valid, sq_full, sq_hit;
  logic [AW-1:0] sq_head_addr;
  logic [DW-1:0] sq_head_data, sq_hit_data;
  logic [CW-1:0] sq_count;

  logic          tag_front_is_load, tag_full;
  logic          ld_grant, st_grant;
  logic          ld_rsp, st_rsp;

  assign op = sb_op_e'(cpu_req_op);

  assign ld_idle    = (ld_state_q == LD_IDLE);
  assign ld_waiting = (ld_state_q == LD_ISSUE);
  assign st_quiet   = !sq_head_valid && (st_inflight_q == '0);

  // request acceptance per operation class
  always_comb begin
    case (op)
      OP_LOAD:     cpu_req_ready = ld_idle;
      OP_STORE:    cpu_req_ready = !sq_full;
      OP_FENCE_LD: cpu_req_ready = ld_idle;
      OP_FENCE_ST: cpu_req_ready = st_quiet;
      default:     cpu_req_ready = ld_idle && st_quiet;
    endcase
  end

  assign accept    = cpu_req_valid && cpu_req_ready;
  assign ld_accept = accept && (op == OP_LOAD);
  assign st_accept = accept && (op == OP_STORE);
  assign fwd_hit   = ld_accept && sq_hit;

  assign ld_rsp = mem_rsp_valid && tag_front_is_load;
  assign st_rsp = mem_rsp_valid && !tag_front_is_load;

  sb_store_queue #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (st_accept),
    .push_addr  (cpu_req_addr),
    .push_data  (cpu_req_wdata),
    .pop_en     (st_grant),
    .look_addr  (cpu_req_addr),
    .head_valid (sq_head_valid),
    .head_addr  (sq_head_addr),
    .head_data  (sq_head_data),
    .full       (sq_full),
    .count      (sq_count),
    .hit        (sq_hit),
    .hit_data   (sq_hit_data)
  );

  sb_tag_fifo #(
    .DEPTH (MAX_OUT)
  ) u_tags (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_en       (ld_grant || st_grant),
    .push_is_load  (ld_grant),
    .pop_en        (mem_rsp_valid),
    .front_is_load (tag_front_is_load),
    .full          (tag_full)
  );

  sb_mem_arb #(
    .AW (AW),
    .DW (DW)
  ) u_arb (
    .ld_req    (ld_waiting),
    .ld_addr   (ld_addr_q),
    .st_req    (sq_head_valid),
    .st_addr   (sq_head_addr),
    .st_data   (sq_head_data),
    .room      (!tag_full),
    .mem_ready (mem_req_ready),
    .mem_valid (mem_req_valid),
    .mem_write (mem_req_write),
    .mem_addr  (mem_req_addr),
    .mem_wdata (mem_req_wdata),
    .ld_grant  (ld_grant),
    .st_grant  (st_grant)
  );

  // load slot next state
  always_comb begin
    ld_state_d = ld_state_q;
    ld_addr_en = 1'b0;
    case (ld_state_q)
      LD_IDLE: begin
        if (ld_accept && !sq_hit) begin
          ld_state_d = LD_ISSUE;
          ld_addr_en = 1'b1;
        end
      end
      LD_ISSUE: begin
        if (ld_grant) begin
          ld_state_d = LD_DATA;
        end
      end
      LD_DATA: begin
        if (ld_rsp) begin
          ld_state_d = LD_IDLE;
        end
      end
      default: ld_state_d = LD_IDLE;
    endcase
  end

  // stores in flight at memory
  always_comb begin
    st_inflight_d = st_inflight_q;
    case ({st_grant, st_rsp})
      2'b10:   st_inflight_d = st_inflight_q + IW'(1);
      2'b01:   st_inflight_d = st_inflight_q - IW'(1);
      default: st_inflight_d = st_inflight_q;
    endcase
  end

  // response to the core
  always_comb begin
    rsp_valid_d = fwd_hit || ld_rsp;
    rsp_data_en = fwd_hit || ld_rsp;
    rsp_data_d  = fwd_hit ? sq_hit_data : mem_rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_state_q    <= LD_IDLE;
      st_inflight_q <= '0;
      rsp_valid_q   <= 1'b0;
    end else begin
      ld_state_q    <= ld_state_d;
      st_inflight_q <= st_inflight_d;
      rsp_valid_q   <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_addr_en) begin
      ld_addr_q <= cpu_req_addr;
    end
    if (rsp_data_en) begin
      rsp_data_q <= rsp_data_d;
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cpu_req_valid,
  input logic                       cpu_req_ready,
  input logic [2:0]                 cpu_req_op,
  input logic                       cpu_rsp_valid,
  input logic                       mem_req_valid,
  input logic                       mem_req_write,
  input logic [$clog2(DEPTH+1)-1:0] sq_count,
  input logic [$clog2(MAX_OUT+1)-1:0] st_inflight,
  input logic                       ld_idle,
  input logic                       ld_waiting,
  input logic                       fwd_hit
);

  logic hs;
  assign hs = cpu_req_valid && cpu_req_ready;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cpu_req_op == OP_STORE) |-> (int'(sq_count) < DEPTH)); // R10

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && ld_waiting) |-> !mem_req_write); // R11

  AST_STORE_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cpu_req_op == OP_FENCE_ST) |-> (sq_count == '0 && st_inflight == '0)); // R6

  AST_LOAD_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cpu_req_op == OP_FENCE_LD) |-> ld_idle); // R7

  AST_FULL_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cpu_req_op >= OP_FENCE_ALL) |-> (ld_idle && sq_count == '0 && st_inflight == '0)); // R8

  AST_FWD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> (cpu_rsp_valid && ld_idle)); // R3

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cpu_req_op == OP_LOAD) |-> ld_idle); // R13

endmodule

bind store_buffer_tso sb_checker #(
  .DEPTH   (DEPTH),
  .MAX_OUT (MAX_OUT)
) u_sb_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_op    (cpu_req_op),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .sq_count      (sq_count),
  .st_inflight   (st_inflight_q),
  .ld_idle       (ld_idle),
  .ld_waiting    (ld_waiting),
  .fwd_hit       (fwd_hit)
);

// File: tb/store_buffer_tso_bench.sv
module store_buffer_tso_bench;

  localparam int DEPTH   = 4;
  localparam int AW      = 4;
  localparam int DW      = 16;
  localparam int MAX_OUT = 2;
  localparam int NWORDS  = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          cpu_req_valid;
  logic          cpu_req_ready;
  logic [2:0]    cpu_req_op;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;

  store_buffer_tso #(
    .DEPTH   (DEPTH),
    .AW      (AW),
    .DW      (DW),
    .MAX_OUT (MAX_OUT)
  ) u_store_buffer_tso (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_op    (cpu_req_op),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [DW-1:0] mem_img [NWORDS];
  logic [DW-1:0] shadow  [NWORDS];
  logic [AW+DW-1:0] exp_wr_q [$];
  logic [DW-1:0]    exp_ld_q [$];
  bit               rq_ld    [$];
  logic [DW-1:0]    rq_data  [$];
  int               rq_due   [$];

  int cyc = 0;
  bit mem_hold = 1'b1;
  int ready_pct = 60;
  int st_sent = 0;
  int st_acked = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 16'h0101 + 16'h0007);
  endfunction

  // memory model: in-order responses, random ready and latency
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    for (int i = 0; i < NWORDS; i++) begin
      mem_img[i] = init_word(i);
      shadow[i]  = init_word(i);
    end
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = rq_data[0];
        if (!rq_ld[0]) st_acked++;
        void'(rq_ld.pop_front());
        void'(rq_data.pop_front());
        void'(rq_due.pop_front());
      end
      mem_req_ready = !mem_hold && ($urandom_range(99) < ready_pct);
      #1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          // R4: writes reach memory in acceptance order
          if (exp_wr_q.size() == 0) begin
            check(1'b0, "R4", "unexpected memory write", {mem_req_addr, mem_req_wdata}, 0);
          end else begin
            logic [AW+DW-1:0] e;
            e = exp_wr_q.pop_front();
            check({mem_req_addr, mem_req_wdata} == e, "R4", "write order",
                  {mem_req_addr, mem_req_wdata}, e);
          end
          mem_img[mem_req_addr] = mem_req_wdata;
          rq_ld.push_back(1'b0);
          rq_data.push_back('0);
        end else begin
          rq_ld.push_back(1'b1);
          rq_data.push_back(mem_img[mem_req_addr]);
        end
        rq_due.push_back(cyc + 1 + int'($urandom_range(2)));
      end
    end
  end

  // load response checker (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && cpu_rsp_valid) begin
        if (exp_ld_q.size() == 0) begin
          check(1'b0, "R9", "unexpected load response", cpu_rsp_rdata, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_ld_q.pop_front();
          check(cpu_rsp_rdata == e, "R9", "load value", cpu_rsp_rdata, e);
        end
      end
    end
  end

  task automatic cpu_issue(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    cpu_req_op    = op;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    cpu_req_valid = 1'b1;
    #1;
    while (!cpu_req_ready) begin
      @(negedge clk);
      #1;
      waits++;
    end
    case (op)
      3'd0: exp_ld_q.push_back(shadow[a]);
      3'd1: begin
        shadow[a] = d;
        exp_wr_q.push_back({a, d});
        st_sent++;
      end
      3'd2: check(exp_ld_q.size() == 0, "R7", "load fence with load outstanding",
                  exp_ld_q.size(), 0);
      3'd3: check(st_sent == st_acked, "R6", "store fence with stores pending",
                  st_sent - st_acked, 0);
      default: check(st_sent == st_acked && exp_ld_q.size() == 0, "R8",
                     "full fence with work pending", st_sent - st_acked + exp_ld_q.size(), 0);
    endcase
    @(posedge clk);
    #1;
    cpu_req_valid = 1'b0;
  endtask

  task automatic probe(input logic [2:0] op, output logic rdy);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cpu_req_op    = op;
    #1;
    rdy = cpu_req_ready;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int w;
    logic r;
    void'($urandom(32'd4242));
    rst_n         = 1'b0;
    cpu_req_valid = 1'b0;
    cpu_req_op    = 3'd0;
    cpu_req_addr  = '0;
    cpu_req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    @(negedge clk);
    #1;
    check(cpu_req_ready == 1'b1, "R12", "ready for load after reset", cpu_req_ready, 1);
    check(mem_req_valid == 1'b0, "R12", "no memory request after reset", mem_req_valid, 0);
    check(cpu_rsp_valid == 1'b0, "R12", "no response after reset", cpu_rsp_valid, 0);

    // R1 R2 R5: stores queue while memory stalls; a load to a new address bypasses them
    mem_hold = 1'b1;
    cpu_issue(3'd1, 4'd1, 16'h1111, w);
    check(w == 0, "R1", "store accepted with memory stalled", w, 0);
    cpu_issue(3'd1, 4'd2, 16'h2222, w);
    check(w == 0, "R5", "second store while first pending", w, 0);
    cpu_issue(3'd0, 4'd5, '0, w);
    @(negedge clk);
    #1;
    check(mem_req_valid && !mem_req_write && mem_req_addr == 4'd5, "R2",
          "load presented ahead of stores", {mem_req_valid, mem_req_write, mem_req_addr}, {1'b1, 1'b0, 4'd5});
    cpu_issue(3'd1, 4'd9, 16'h9999, w);
    check(w == 0, "R5", "store while load outstanding", w, 0);
    mem_hold = 1'b0;
    cpu_issue(3'd4, '0, '0, w);

    // R3: two stores to one address, load returns the younger
    mem_hold = 1'b1;
    cpu_issue(3'd1, 4'd3, 16'h00A1, w);
    cpu_issue(3'd1, 4'd3, 16'h00B2, w);
    cpu_issue(3'd0, 4'd3, '0, w);
    check(cpu_rsp_valid && cpu_rsp_rdata == 16'h00B2, "R3", "forwarded youngest data",
          cpu_rsp_rdata, 16'h00B2);
    check(mem_req_write == 1'b1, "R3", "matching load not sent to memory", mem_req_write, 1);
    mem_hold = 1'b0;
    cpu_issue(3'd3, '0, '0, w);

    // R10 and fence stalls with a full queue
    mem_hold = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      cpu_issue(3'd1, AW'(i + 8), DW'(16'h5000 + i), w);
    end
    probe(3'd1, r);
    check(r == 1'b0, "R10", "store stalls on full queue", r, 0);
    probe(3'd2, r);
    check(r == 1'b1, "R7", "load fence not held by stores", r, 1);
    probe(3'd3, r);
    check(r == 1'b0, "R6", "store fence held by queued stores", r, 0);
    probe(3'd4, r);
    check(r == 1'b0, "R8", "full fence held by queued stores", r, 0);
    probe(3'd6, r);
    check(r == 1'b0, "R8", "op 6 acts as full fence", r, 0);
    mem_hold = 1'b0;
    cpu_issue(3'd3, '0, '0, w);

    // R13 R7: outstanding load
    mem_hold = 1'b1;
    cpu_issue(3'd0, 4'd6, '0, w);
    probe(3'd0, r);
    check(r == 1'b0, "R13", "second load held", r, 0);
    probe(3'd2, r);
    check(r == 1'b0, "R7", "load fence held by load", r, 0);
    probe(3'd1, r);
    check(r == 1'b1, "R5", "store accepted with load outstanding", r, 1);
    probe(3'd3, r);
    check(r == 1'b1, "R6", "store fence free with no stores", r, 1);
    probe(3'd5, r);
    check(r == 1'b0, "R8", "op 5 held by load", r, 0);
    mem_hold = 1'b0;
    cpu_issue(3'd2, '0, '0, w);

    // random mix (R4 R9 R11 and fences)
    for (int n = 0; n < 1500; n++) begin
      int sel;
      logic [2:0] op;
      sel = int'($urandom_range(99));
      if (sel < 40)      op = 3'd0;
      else if (sel < 80) op = 3'd1;
      else if (sel < 87) op = 3'd2;
      else if (sel < 94) op = 3'd3;
      else               op = 3'(4 + $urandom_range(3));
      cpu_issue(op, AW'($urandom_range(7)), DW'($urandom), w);
    end
    cpu_issue(3'd4, '0, '0, w);
    repeat (4) @(negedge clk);
    check(exp_wr_q.size() == 0, "R4", "all stores written", exp_wr_q.size(), 0);
    check(exp_ld_q.size() == 0, "R9", "all loads answered", exp_ld_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule